// File: doc/BRIEF.md
# Oversampling Serial Receiver with Sticky Error Flags

This block receives asynchronous serial characters on a single input line. The line is first brought into the clock domain through a short flop chain. Each bit period then lasts a fixed number of oversample ticks, and the block reads the line three times around the middle of every bit. The bit takes whichever value appears in at least two of the three reads. A start bit that disappears before mid-bit counts as a glitch, and the receiver returns to idle. The character length can be seven, eight or nine bits. A parity bit with even or odd sense can follow the data bits.

Each finished character goes into a holding register. A small register port lets software read that register, read and clear the status flags, and set or clear the interrupt enables. The flags record data ready, overrun, framing error, parity error and noise. All of them are sticky. The error flags clear only when a one is written to their bit, and data ready clears when the held character is read. A single interrupt line is raised while any flag is set together with its enable bit.

Top module: `uart_rx_flagged`

## Requirements
- R1: Data bits arrive least significant bit first, each decided by the majority of the reads at oversample ticks 7, 8 and 9 of its 16-tick period. The finished character appears at register address 0 (zero-extended), and status bit 0 (data ready) is set.
- R2: If a data bit has exactly one read that disagrees with the other two, status bit 15 (noise) is set, and the character still holds the majority values.
- R3: If two of a data bit's three reads are inverted, the bit takes the inverted value, and noise (bit 15) is set.
- R4: A stop bit that is decided low sets status bit 13 (framing error), and the character is stored.
- R5: With parity enabled, a parity mismatch sets status bit 14. The parity sense is 0 for even (data bits plus parity bit hold an even count of ones) and 1 for odd. With parity disabled, no parity bit is expected and bit 14 is never set.
- R6: If a character finishes while data ready is still set, status bit 8 (overrun) is set, and the older character stays in the holding register.
- R7: Writing the status register (address 1) clears exactly the error flags (bits 8, 13, 14, 15) written as one. Zeros, and a one at bit 0, have no effect.
- R8: A write to address 2 sets the enable bits written as one, and a write to address 3 clears them. Both addresses read back the enables. Only bits 0, 8, 13, 14 and 15 can be set.
- R9: `irq_o` is high exactly while some status flag and its same-position enable bit are both set.
- R10: A break makes the line low for the whole character, with all data bits, parity and stop decided low. A break stores the character and sets framing error, but leaves the noise flag unchanged even when a sample disagreed.
- R11: Character length code 0 selects 7 data bits, code 1 selects 8, and codes 2 and 3 select 9.
- R12: Reading address 0 with the read strobe clears data ready on the following clock edge.
- R13: A low pulse that has ended by the mid-bit votes of the start bit stores nothing. The receiver then accepts the next real character.
- R14: After reset, the holding register, all status flags, all enables and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial input line, idle high |
| os_tick_i | input | 1 | Oversample tick, 16 per bit period |
| par_en_i | input | 1 | Expect and check a parity bit |
| par_odd_i | input | 1 | Parity sense: 0 even, 1 odd |
| char_len_i | input | 2 | Character length code |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address: 0 data, 1 status, 2 enable set, 3 enable clear |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from address |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, 9-bit maximum character, two synchronizer stages. It also holds the oversample tick high, so one bench clock equals one tick. Because the line is driven per tick, a one-cycle inversion lands on exactly one vote read, and a two-cycle inversion lands on two. This makes single-sample noise, two-sample bit flips, noise inside a break and short start glitches all reproducible. The 9-bit maximum lets all three character lengths be exercised.

// File: rtl/urx_pkg.sv
package urx_pkg;
    localparam int STAT_W  = 16;
    localparam int BIT_RDY = 0;
    localparam int BIT_OVR = 8;
    localparam int BIT_FRM = 13;
    localparam int BIT_PAR = 14;
    localparam int BIT_NSE = 15;

    localparam logic [STAT_W-1:0] EN_MASK =
        STAT_W'((1 << BIT_RDY) | (1 << BIT_OVR) | (1 << BIT_FRM) |
                (1 << BIT_PAR) | (1 << BIT_NSE));

    localparam logic [1:0] ADDR_DATA  = 2'd0;
    localparam logic [1:0] ADDR_STAT  = 2'd1;
    localparam logic [1:0] ADDR_ENSET = 2'd2;
    localparam logic [1:0] ADDR_ENCLR = 2'd3;

    typedef enum logic [2:0] {
        RX_IDLE   = 3'd0,
        RX_START  = 3'd1,
        RX_DATA   = 3'd2,
        RX_PARITY = 3'd3,
        RX_STOP   = 3'd4
    } rx_state_e;
endpackage

// File: rtl/urx_vote.sv
module urx_vote (
    input  logic [1:0] early_i,
    input  logic       now_i,
    output logic       bit_o,
    output logic       split_o
);
    always_comb begin
        bit_o   = (early_i[0] & early_i[1]) | (early_i[0] & now_i) | (early_i[1] & now_i);
        split_o = !((early_i[0] == early_i[1]) && (early_i[1] == now_i));
    end
endmodule

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stg_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[0] <= RST_VAL;
                else        stg_q[0] <= d_i;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/urx_frame.sv
module urx_frame
    import urx_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int MAX_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_i,
    input  logic                tick_i,
    input  logic                par_en_i,
    input  logic                par_odd_i,
    input  logic [1:0]          char_len_i,
    output logic                done_o,
    output logic [MAX_BITS-1:0] data_o,
    output logic                frm_o,
    output logic                perr_o,
    output logic                noise_o,
    output logic                brk_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(MAX_BITS);
    localparam logic [CNT_W-1:0] T_VA  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] T_VB  = CNT_W'(OSR/2);
    localparam logic [CNT_W-1:0] T_VC  = CNT_W'(OSR/2 + 1);
    localparam logic [CNT_W-1:0] T_END = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e             st;
        logic [CNT_W-1:0]      cnt;
        logic [IDX_W-1:0]      idx;
        logic [1:0]            early;
        logic [MAX_BITS-1:0]   data;
        logic                  noisy;
        logic                  pbit;
        logic                  done;
        logic                  frm;
        logic                  perr;
        logic                  brk;
        logic                  nse;
    } frm_s;

    frm_s q, d;
    logic v_bit, v_split;
    logic [IDX_W-1:0] last_idx;

    urx_vote u_vote (
        .early_i (q.early),
        .now_i   (line_i),
        .bit_o   (v_bit),
        .split_o (v_split)
    );

    always_comb begin
        case (char_len_i)
            2'd0:    last_idx = IDX_W'(MAX_BITS - 3);
            2'd1:    last_idx = IDX_W'(MAX_BITS - 2);
            default: last_idx = IDX_W'(MAX_BITS - 1);
        endcase
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (tick_i) begin
            if (q.st == RX_IDLE) begin
                if (!line_i) begin
                    d.st  = RX_START;
                    d.cnt = CNT_W'(1);
                end
            end else begin
                d.cnt = (q.cnt == T_END) ? '0 : q.cnt + 1'b1;
                if (q.cnt == T_VA) d.early[0] = line_i;
                if (q.cnt == T_VB) d.early[1] = line_i;
                if (q.cnt == T_VC) begin
                    case (q.st)
                        RX_START: begin
                            if (v_bit) begin
                                d.st = RX_IDLE;
                            end else begin
                                d.data  = '0;
                                d.noisy = 1'b0;
                                d.pbit  = 1'b0;
                                d.idx   = '0;
                            end
                        end
                        RX_DATA: begin
                            d.data[q.idx] = v_bit;
                            d.noisy       = q.noisy | v_split;
                        end
                        RX_PARITY: d.pbit = v_bit;
                        RX_STOP: begin
                            d.done = 1'b1;
                            d.frm  = !v_bit;
                            d.perr = par_en_i & ((^q.data ^ q.pbit) != par_odd_i);
                            d.brk  = (q.data == '0) && !v_bit && !(par_en_i && q.pbit);
                            d.nse  = q.noisy;
                            d.st   = RX_IDLE;
                        end
                        default: d.st = RX_IDLE;
                    endcase
                end
                if (q.cnt == T_END) begin
                    case (q.st)
                        RX_START: d.st = RX_DATA;
                        RX_DATA: begin
                            if (q.idx == last_idx) d.st = par_en_i ? RX_PARITY : RX_STOP;
                            else                   d.idx = q.idx + 1'b1;
                        end
                        RX_PARITY: d.st = RX_STOP;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o  = q.done;
    assign data_o  = q.data;
    assign frm_o   = q.frm;
    assign perr_o  = q.perr;
    assign noise_o = q.nse;
    assign brk_o   = q.brk;
endmodule

// File: rtl/urx_status.sv
module urx_status
    import urx_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DW-1:0]     data_i,
    input  logic              frm_i,
    input  logic              perr_i,
    input  logic              noise_i,
    input  logic              brk_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [1:0]        addr_i,
    input  logic [STAT_W-1:0] wdata_i,
    output logic [STAT_W-1:0] rdata_o,
    output logic [STAT_W-1:0] stat_o,
    output logic [STAT_W-1:0] en_o,
    output logic [DW-1:0]     held_o,
    output logic              irq_o
);
    typedef struct packed {
        logic              rdy;
        logic              ovr;
        logic              frm;
        logic              per;
        logic              nse;
        logic [STAT_W-1:0] en;
        logic [DW-1:0]     data;
    } st_s;

    st_s q, d;
    logic              rd_clear;
    logic [STAT_W-1:0] w1c;
    logic [STAT_W-1:0] stat_vec;

    always_comb begin
        stat_vec          = '0;
        stat_vec[BIT_RDY] = q.rdy;
        stat_vec[BIT_OVR] = q.ovr;
        stat_vec[BIT_FRM] = q.frm;
        stat_vec[BIT_PAR] = q.per;
        stat_vec[BIT_NSE] = q.nse;
    end

    always_comb begin
        rd_clear = rd_i && (addr_i == ADDR_DATA);
        w1c      = (wr_i && (addr_i == ADDR_STAT)) ? wdata_i : '0;

        d     = q;
        d.rdy = q.rdy & !rd_clear;
        d.ovr = q.ovr & !w1c[BIT_OVR];
        d.frm = q.frm & !w1c[BIT_FRM];
        d.per = q.per & !w1c[BIT_PAR];
        d.nse = q.nse & !w1c[BIT_NSE];

        if (wr_i && (addr_i == ADDR_ENSET)) d.en = q.en | (wdata_i & EN_MASK);
        if (wr_i && (addr_i == ADDR_ENCLR)) d.en = q.en & ~(wdata_i & EN_MASK);

        if (done_i) begin
            if (q.rdy && !rd_clear) begin
                d.ovr = 1'b1;
            end else begin
                d.rdy  = 1'b1;
                d.data = data_i;
                if (frm_i)             d.frm = 1'b1;
                if (perr_i)            d.per = 1'b1;
                if (noise_i && !brk_i) d.nse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (addr_i)
            ADDR_DATA: rdata_o = {{(STAT_W-DW){1'b0}}, q.data};
            ADDR_STAT: rdata_o = stat_vec;
            default:   rdata_o = q.en;
        endcase
    end

    assign irq_o  = |(stat_vec & q.en);
    assign stat_o = stat_vec;
    assign en_o   = q.en;
    assign held_o = q.data;
endmodule

// File: rtl/uart_rx_flagged.sv
module uart_rx_flagged
    import urx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int MAX_BITS    = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rxd_i,
    input  logic        os_tick_i,
    input  logic        par_en_i,
    input  logic        par_odd_i,
    input  logic [1:0]  char_len_i,
    input  logic        reg_wr_i,
    input  logic        reg_rd_i,
    input  logic [1:0]  reg_addr_i,
    input  logic [15:0] reg_wdata_i,
    output logic [15:0] reg_rdata_o,
    output logic        irq_o
);
    logic                line_s;
    logic                rx_done, rx_frm, rx_perr, rx_nse, rx_brk;
    logic [MAX_BITS-1:0] rx_data;
    logic [MAX_BITS-1:0] held_data;
    logic [STAT_W-1:0]   stat_vec, en_vec;

    urx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rxd_i),
        .q_o   (line_s)
    );

    urx_frame #(.OSR(OSR), .MAX_BITS(MAX_BITS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_s),
        .tick_i     (os_tick_i),
        .par_en_i   (par_en_i),
        .par_odd_i  (par_odd_i),
        .char_len_i (char_len_i),
        .done_o     (rx_done),
        .data_o     (rx_data),
        .frm_o      (rx_frm),
        .perr_o     (rx_perr),
        .noise_o    (rx_nse),
        .brk_o      (rx_brk)
    );

    urx_status #(.DW(MAX_BITS)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (rx_done),
        .data_i  (rx_data),
        .frm_i   (rx_frm),
        .perr_i  (rx_perr),
        .noise_i (rx_nse),
        .brk_i   (rx_brk),
        .wr_i    (reg_wr_i),
        .rd_i    (reg_rd_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .stat_o  (stat_vec),
        .en_o    (en_vec),
        .held_o  (held_data),
        .irq_o   (irq_o)
    );
endmodule

// File: rtl/urx_checker.sv
module urx_checker
    import urx_pkg::*;
#(
    parameter int DW = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_i,
    input logic              rd_i,
    input logic [1:0]        addr_i,
    input logic [STAT_W-1:0] wdata_i,
    input logic              done_i,
    input logic              brk_i,
    input logic [STAT_W-1:0] stat_i,
    input logic [STAT_W-1:0] en_i,
    input logic [DW-1:0]     held_i
);
    logic data_rd, stat_wr;
    assign data_rd = rd_i && (addr_i == ADDR_DATA);
    assign stat_wr = wr_i && (addr_i == ADDR_STAT);

    AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !done_i) |=> !stat_i[BIT_RDY]); // R12

    AST_OVERRUN_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && stat_i[BIT_RDY] && !data_rd) |=> (stat_i[BIT_OVR] && $stable(held_i))); // R6

    AST_FRAMING_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wdata_i[BIT_FRM] && !done_i) |=> !stat_i[BIT_FRM]); // R7

    AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (addr_i == ADDR_ENSET) && wdata_i[BIT_NSE]) |=> en_i[BIT_NSE]); // R8

    AST_ENABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (addr_i == ADDR_ENCLR) && wdata_i[BIT_RDY]) |=> !en_i[BIT_RDY]); // R8

    AST_BREAK_NOISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && brk_i && !stat_wr) |=> $stable(stat_i[BIT_NSE])); // R10
endmodule

bind uart_rx_flagged urx_checker #(.DW(MAX_BITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .done_i  (rx_done),
    .brk_i   (rx_brk),
    .stat_i  (stat_vec),
    .en_i    (en_vec),
    .held_i  (held_data)
);

// File: tb/uart_rx_flagged_bench.sv
module uart_rx_flagged_bench;
    localparam int CLK_PERIOD = 10;
    localparam int OSR        = 16;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic        tick = 1'b1;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic [1:0]  clen = 2'd1;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_flagged u_uart_rx_flagged (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxd_i       (rxd),
        .os_tick_i   (tick),
        .par_en_i    (par_en),
        .par_odd_i   (par_odd),
        .char_len_i  (clen),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; rd = 1'b0;
        #1 v = rdata;
    endtask

    task automatic take(output logic [15:0] v);
        @(negedge clk);
        addr = 2'd0; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic irq_now(output logic v);
        @(negedge clk);
        #1 v = irq;
    endtask

    task automatic drive_bit(input logic v, input logic f7, input logic f8);
        for (int k = 0; k < OSR; k++) begin
            @(negedge clk);
            rxd = v ^ ((k == 7) && f7) ^ ((k == 8) && f8);
        end
    endtask

    task automatic send(input logic [8:0] dat, input int nb, input bit pen, input bit pval,
                        input bit stopv, input int fbit, input bit f7, input bit f8);
        drive_bit(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < nb; i++) drive_bit(dat[i], (i == fbit) && f7, (i == fbit) && f8);
        if (pen) drive_bit(pval, 1'b0, 1'b0);
        drive_bit(stopv, 1'b0, 1'b0);
        @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        logic i;
        peek(2'd0, v); chk("R14 data", v, 16'h0000);
        peek(2'd1, v); chk("R14 status", v, 16'h0000);
        peek(2'd2, v); chk("R14 enables", v, 16'h0000);
        irq_now(i);    chk("R14 irq", {15'h0, i}, 16'h0000);
    endtask

    task automatic t_basic();
        logic [15:0] v;
        send(9'h0A5, 8, 0, 0, 1, -1, 0, 0);
        peek(2'd1, v); chk("R1 ready", v, 16'h0001);
        take(v);       chk("R1 data", v, 16'h00A5);
        peek(2'd1, v); chk("R12 ready cleared by read", v, 16'h0000);
    endtask

    task automatic t_noise();
        logic [15:0] v;
        send(9'h03C, 8, 0, 0, 1, 2, 0, 1);
        peek(2'd1, v); chk("R2 noise flag", v, 16'h8001);
        take(v);       chk("R2 majority data", v, 16'h003C);
        wreg(2'd1, 16'h8000);
        peek(2'd1, v); chk("R7 noise cleared", v, 16'h0000);
        send(9'h03C, 8, 0, 0, 1, 0, 1, 1);
        take(v);       chk("R3 flipped bit", v, 16'h003D);
        peek(2'd1, v); chk("R3 noise flag", v, 16'h8000);
        wreg(2'd1, 16'h8000);
    endtask

    task automatic t_frame();
        logic [15:0] v;
        send(9'h055, 8, 0, 0, 0, -1, 0, 0);
        peek(2'd1, v); chk("R4 framing", v, 16'h2001);
        peek(2'd0, v); chk("R4 data kept", v, 16'h0055);
        wreg(2'd1, 16'h0101);
        peek(2'd1, v); chk("R7 unrelated ones no effect", v, 16'h2001);
        wreg(2'd1, 16'h0000);
        peek(2'd1, v); chk("R7 zero write no effect", v, 16'h2001);
        wreg(2'd1, 16'h2000);
        peek(2'd1, v); chk("R7 framing cleared", v, 16'h0001);
        take(v);
    endtask

    task automatic t_parity();
        logic [15:0] v;
        par_en = 1'b1; par_odd = 1'b0;
        send(9'h007, 8, 1, 0, 1, -1, 0, 0);
        peek(2'd1, v); chk("R5 even mismatch", v, 16'h4001);
        take(v);       chk("R5 data", v, 16'h0007);
        wreg(2'd1, 16'h4000);
        send(9'h007, 8, 1, 1, 1, -1, 0, 0);
        peek(2'd1, v); chk("R5 even match", v, 16'h0001);
        take(v);
        par_odd = 1'b1;
        send(9'h007, 8, 1, 0, 1, -1, 0, 0);
        peek(2'd1, v); chk("R5 odd match", v, 16'h0001);
        take(v);
        send(9'h007, 8, 1, 1, 1, -1, 0, 0);
        peek(2'd1, v); chk("R5 odd mismatch", v, 16'h4001);
        take(v);
        wreg(2'd1, 16'h4000);
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_overrun();
        logic [15:0] v;
        send(9'h011, 8, 0, 0, 1, -1, 0, 0);
        send(9'h022, 8, 0, 0, 1, -1, 0, 0);
        peek(2'd1, v); chk("R6 overrun flag", v, 16'h0101);
        take(v);       chk("R6 older kept", v, 16'h0011);
        wreg(2'd1, 16'h0100);
        peek(2'd1, v); chk("R7 overrun cleared", v, 16'h0000);
    endtask

    task automatic t_length();
        logic [15:0] v;
        clen = 2'd0;
        send(9'h05A, 7, 0, 0, 1, -1, 0, 0);
        take(v);       chk("R11 seven bits", v, 16'h005A);
        peek(2'd1, v); chk("R11 seven bits status", v, 16'h0000);
        clen = 2'd2;
        send(9'h1A5, 9, 0, 0, 1, -1, 0, 0);
        take(v);       chk("R11 nine bits", v, 16'h01A5);
        clen = 2'd3;
        send(9'h10F, 9, 0, 0, 1, -1, 0, 0);
        take(v);       chk("R11 code 3 nine bits", v, 16'h010F);
        clen = 2'd1;
    endtask

    task automatic t_irq();
        logic [15:0] v;
        logic i;
        wreg(2'd2, 16'hFFFF);
        peek(2'd2, v); chk("R8 only implemented enables", v, 16'hE101);
        peek(2'd3, v); chk("R8 clear address reads enables", v, 16'hE101);
        irq_now(i);    chk("R9 no flag no irq", {15'h0, i}, 16'h0000);
        send(9'h042, 8, 0, 0, 1, -1, 0, 0);
        irq_now(i);    chk("R9 ready raises irq", {15'h0, i}, 16'h0001);
        take(v);
        irq_now(i);    chk("R9 irq drops after read", {15'h0, i}, 16'h0000);
        wreg(2'd3, 16'h0001);
        peek(2'd2, v); chk("R8 ready enable cleared", v, 16'hE100);
        send(9'h043, 8, 0, 0, 1, -1, 0, 0);
        irq_now(i);    chk("R9 disabled flag no irq", {15'h0, i}, 16'h0000);
        send(9'h044, 8, 0, 0, 1, -1, 0, 0);
        irq_now(i);    chk("R9 overrun raises irq", {15'h0, i}, 16'h0001);
        take(v);
        wreg(2'd1, 16'h0100);
        wreg(2'd3, 16'hFFFF);
        peek(2'd2, v); chk("R8 all enables cleared", v, 16'h0000);
    endtask

    task automatic t_break();
        logic [15:0] v;
        send(9'h000, 8, 0, 0, 0, 3, 0, 1);
        peek(2'd1, v); chk("R10 break framing no noise", v, 16'h2001);
        take(v);       chk("R10 break data", v, 16'h0000);
        wreg(2'd1, 16'h2000);
    endtask

    task automatic t_glitch();
        logic [15:0] v;
        @(negedge clk);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        peek(2'd1, v); chk("R13 glitch ignored", v, 16'h0000);
        send(9'h081, 8, 0, 0, 1, -1, 0, 0);
        take(v);       chk("R13 next character received", v, 16'h0081);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_noise();
        t_frame();
        t_parity();
        t_overrun();
        t_length();
        t_irq();
        t_break();
        t_glitch();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule